// File: doc/BRIEF.md
# Status Flag Bit-Manipulation Unit

This unit carries out the single-bit instructions of a small 8-bit microcontroller core that touch the status register. One class of instruction sets or clears any one of the eight status flags. A second copies the T flag into a chosen bit of a general register. A third copies a chosen register bit into the T flag. The T flag therefore works as a one-bit path between the status register and any bit of any of the 32 general registers.

An instruction word is presented together with a valid strobe. The unit registers its result on the next rising clock edge. The unit holds its own 32 x 8 general register file. A combinational debug port can read any entry of that file. Words that match none of the supported encodings raise an illegal-opcode output for one cycle and leave all state unchanged.

Top module: `sfbit_unit`

## Requirements
- R1: While `rst_i` is high at a rising clock edge (synchronous, active-high reset), the status register, all 32 general registers and `illegal_o` are cleared to zero.
- R2: A valid word with bits 15:8 = 8'h94, bits 3:0 = 4'h8 and bit 7 = 0 sets status bit `word[6:4]` to 1.
- R3: The same pattern with bit 7 = 1 clears status bit `word[6:4]` to 0. A flag instruction in either direction leaves the other seven status bits unchanged and does not modify the register file.
- R4: The flag select field maps directly to the bit position in `status_o`: 0=C, 1=Z, 2=N, 3=V, 4=S, 5=H, 6=T, 7=I. All eight indices work in both directions.
- R5: A valid word with bits 15:9 = 7'b1111100 and bit 3 = 0 (bit load) writes T (`status_o[6]`) into bit `word[2:0]` of register `word[8:4]`. The other bits of that register, all other registers and the status register are unchanged.
- R6: A valid word with bits 15:9 = 7'b1111101 (bit store) sets T to bit `word[2:0]` of register `word[8:4]`, whatever the value of bit 3. The register file and the other status bits are unchanged.
- R7: A valid word that matches none of the encodings above, including a bit-load word with bit 3 = 1, drives `illegal_o` high for exactly the next cycle and changes neither the status register nor any general register. `illegal_o` is low after every other cycle.
- R8: When `instr_valid_i` is low, the instruction word is ignored and no state changes.
- R9: The effect of an instruction is not visible before the rising edge at which it is sampled, and it is visible right after that edge.
- R10: `dbg_data_o` shows, combinationally, the current contents of the register selected by `dbg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| dbg_addr_i | input | 5 | Debug read register index |
| dbg_data_o | output | 8 | Debug read data |
| status_o | output | 8 | Status register (bit 6 is T) |
| illegal_o | output | 1 | Previous valid word was not a supported instruction |

## Verification
The flag instructions are driven for every select index, first setting all eight flags and then clearing them again. This separates a wrong index-to-bit mapping from a fault that disturbs neighbouring bits. Register contents are first built up through bit loads with T both set and cleared. Round trips of bit store followed by bit load are then run across different register and bit pairs, some with bit 3 set in the store word. These show whether the register index, the bit index and the T path are each decoded on their own. Near-miss words are also driven, together with idle cycles that carry a valid-looking word. A bench model compares every output and all 32 registers after each instruction, so a stray state change is caught.

// File: rtl/sfbit_pkg.sv
package sfbit_pkg;

    localparam int unsigned STATUS_W = 8;
    localparam int unsigned T_POS    = 6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FLAG,
        OP_BLD,
        OP_BST,
        OP_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic        clear;
        logic [2:0]  flag_sel;
        logic [4:0]  reg_idx;
        logic [2:0]  bit_idx;
    } dec_t;

    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic                illegal;
    } state_t;

endpackage

// File: rtl/sfbit_decode.sv
module sfbit_decode
    import sfbit_pkg::*;
(
    input  logic [15:0] instr_i,
    input  logic        valid_i,
    output dec_t        dec_o
);

    logic is_flag;
    logic is_bld;
    logic is_bst;

    always_comb begin
        is_flag = (instr_i[15:8] == 8'h94) && (instr_i[3:0] == 4'h8);
        is_bld  = (instr_i[15:9] == 7'b1111100) && !instr_i[3];
        is_bst  = (instr_i[15:9] == 7'b1111101);

        dec_o          = '0;
        dec_o.clear    = instr_i[7];
        dec_o.flag_sel = instr_i[6:4];
        dec_o.reg_idx  = instr_i[8:4];
        dec_o.bit_idx  = instr_i[2:0];

        if (!valid_i)      dec_o.kind = OP_NONE;
        else if (is_flag)  dec_o.kind = OP_FLAG;
        else if (is_bld)   dec_o.kind = OP_BLD;
        else if (is_bst)   dec_o.kind = OP_BST;
        else               dec_o.kind = OP_BAD;
    end

endmodule

// File: rtl/sfbit_regs.sv
module sfbit_regs #(
    parameter  int unsigned N  = 32,
    parameter  int unsigned W  = 8,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [W-1:0]  rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_b_o
);

    logic [W-1:0] mem_q [N];
    logic [W-1:0] mem_d [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we_i && (waddr_i == AW'(g))) begin
                mem_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) mem_q[g] <= '0;
            else       mem_q[g] <= mem_d[g];
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    // R5
    write_lands_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/sfbit_unit.sv
module sfbit_unit
    import sfbit_pkg::*;
#(
    parameter  int unsigned NREGS = 32,
    parameter  int unsigned REG_W = 8,
    localparam int unsigned AW    = $clog2(NREGS),
    localparam int unsigned BW    = $clog2(REG_W)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [15:0]         instr_i,
    input  logic                instr_valid_i,
    input  logic [AW-1:0]       dbg_addr_i,
    output logic [REG_W-1:0]    dbg_data_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                illegal_o
);

    dec_t             dec;
    state_t           st_d;
    state_t           st_q;
    logic             rf_we;
    logic [REG_W-1:0] rf_wdata;
    logic [REG_W-1:0] rf_rdata;
    logic [AW-1:0]    op_reg;
    logic [BW-1:0]    op_bit;

    sfbit_decode i_decode (
        .instr_i (instr_i),
        .valid_i (instr_valid_i),
        .dec_o   (dec)
    );

    assign op_reg = AW'(dec.reg_idx);
    assign op_bit = BW'(dec.bit_idx);

    sfbit_regs #(
        .N (NREGS),
        .W (REG_W)
    ) i_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (rf_we),
        .waddr_i   (op_reg),
        .wdata_i   (rf_wdata),
        .raddr_a_i (op_reg),
        .rdata_a_o (rf_rdata),
        .raddr_b_i (dbg_addr_i),
        .rdata_b_o (dbg_data_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        rf_we        = 1'b0;
        rf_wdata     = rf_rdata;
        unique case (dec.kind)
            OP_FLAG: st_d.status[dec.flag_sel] = ~dec.clear;
            OP_BLD: begin
                rf_we            = 1'b1;
                rf_wdata[op_bit] = st_q.status[T_POS];
            end
            OP_BST:  st_d.status[T_POS] = rf_rdata[op_bit];
            OP_BAD:  st_d.illegal = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign status_o  = st_q.status;
    assign illegal_o = st_q.illegal;

    // R7
    illegal_keeps_status_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.illegal |-> $stable(st_q.status));

    // R3
    flag_neighbours_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec.kind == OP_FLAG) |=>
        (((st_q.status ^ $past(st_q.status)) & ~(8'h01 << $past(dec.flag_sel))) == 8'h00));

    // R2
    flag_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec.kind == OP_FLAG) |=> (st_q.status[$past(dec.flag_sel)] == !$past(dec.clear)));

    // R6
    store_to_t_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec.kind == OP_BST) |=> (st_q.status[T_POS] == $past(rf_rdata[op_bit])));

    // R8
    idle_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !instr_valid_i |=> ($stable(st_q.status) && !st_q.illegal));

endmodule

// File: tb/test_sfbit_unit.sv
module test_sfbit_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] instr;
    logic        valid;
    logic [4:0]  dbg_addr;
    logic [7:0]  dbg_data;
    logic [7:0]  status;
    logic        illegal;

    int tests  = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] ref_regs [32];
    logic [7:0] ref_status;
    logic       ref_illegal;

    always #4 clk = ~clk;

    sfbit_unit i_sfbit_unit (
        .clk_i         (clk),
        .rst_i         (rst),
        .instr_i       (instr),
        .instr_valid_i (valid),
        .dbg_addr_i    (dbg_addr),
        .dbg_data_o    (dbg_data),
        .status_o      (status),
        .illegal_o     (illegal)
    );

    task automatic check(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("[TB] FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] flag_w(input int sel, input bit clr);
        return 16'h9408 | (16'(clr) << 7) | (16'(sel) << 4);
    endfunction
    function automatic logic [15:0] bld_w(input int r, input int b);
        return 16'hF800 | (16'(r) << 4) | 16'(b);
    endfunction
    function automatic logic [15:0] bst_w(input int r, input int b);
        return 16'hFA00 | (16'(r) << 4) | 16'(b);
    endfunction

    task automatic model_step(input logic [15:0] w, input logic v);
        int r;
        int b;
        ref_illegal = 1'b0;
        if (!v) return;
        r = int'(w[8:4]);
        b = int'(w[2:0]);
        if (w[15:8] == 8'h94 && w[3:0] == 4'h8) begin
            ref_status[w[6:4]] = !w[7];
        end else if (w[15:9] == 7'b1111100 && !w[3]) begin
            ref_regs[r][b] = ref_status[6];
        end else if (w[15:9] == 7'b1111101) begin
            ref_status[6] = ref_regs[r][b];
        end else begin
            ref_illegal = 1'b1;
        end
    endtask

    // Runs from one ns after a rising edge; all samples land on odd offsets.
    task automatic compare_all(input string tag);
        int bad = 0;
        check(int'(status), int'(ref_status), tag);
        check(int'(illegal), int'(ref_illegal), "R7");
        for (int i = 0; i < 32; i++) begin
            dbg_addr = 5'(i);
            #2;
            if (dbg_data !== ref_regs[i]) begin
                bad++;
                $display("[TB] FAIL R10: reg %0d actual %0h expected %0h", i, dbg_data, ref_regs[i]);
            end
        end
        tests++;
        if (bad != 0) fails++;
    endtask

    task automatic exec(input logic [15:0] w, input logic v, input string tag);
        @(negedge clk);
        instr = w;
        valid = v;
        #1;
        check(int'(status), int'(ref_status), "R9");
        @(posedge clk);
        #1;
        valid = 1'b0;
        model_step(w, v);
        compare_all(tag);
    endtask

    initial begin
        rst      = 1'b1;
        instr    = 16'h0000;
        valid    = 1'b0;
        dbg_addr = 5'd0;
        ref_status  = 8'h00;
        ref_illegal = 1'b0;
        for (int i = 0; i < 32; i++) ref_regs[i] = 8'h00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare_all("R1");

        // R2 / R4: set every flag, check the exact bit each time
        for (int s = 0; s < 8; s++) begin
            exec(flag_w(s, 1'b0), 1'b1, "R2");
            check(int'(status), (1 << (s + 1)) - 1, "R4");
        end
        // R3 / R4: clear every flag in a different order
        for (int s = 7; s >= 0; s--) begin
            exec(flag_w(s, 1'b1), 1'b1, "R3");
            check(int'(status), (1 << s) - 1, "R4");
        end
        exec(flag_w(3, 1'b0), 1'b1, "R2");
        exec(flag_w(5, 1'b0), 1'b1, "R2");
        exec(flag_w(3, 1'b1), 1'b1, "R3");
        check(int'(status), 32'h20, "R3");

        // R8: a valid-looking word with the strobe low
        exec(flag_w(0, 1'b0), 1'b0, "R8");
        exec(16'h0000, 1'b0, "R8");
        check(int'(illegal), 0, "R8");

        // R5: build register contents with T set and cleared
        exec(flag_w(6, 1'b0), 1'b1, "R2");
        exec(bld_w(0, 0), 1'b1, "R5");
        exec(bld_w(0, 7), 1'b1, "R5");
        exec(bld_w(31, 3), 1'b1, "R5");
        exec(bld_w(17, 5), 1'b1, "R5");
        exec(bld_w(17, 6), 1'b1, "R5");
        exec(flag_w(6, 1'b1), 1'b1, "R3");
        exec(bld_w(17, 5), 1'b1, "R5");
        check(int'(ref_regs[17]), 32'h40, "R5");

        // R6 + R5: round trips store then load across pairs
        exec(bst_w(0, 7), 1'b1, "R6");
        exec(bld_w(9, 2), 1'b1, "R5");
        exec(bst_w(31, 3), 1'b1, "R6");
        exec(bld_w(4, 0), 1'b1, "R5");
        exec(bst_w(31, 2) | 16'h0008, 1'b1, "R6");
        exec(bld_w(31, 3), 1'b1, "R5");
        exec(bst_w(17, 6) | 16'h0008, 1'b1, "R6");
        exec(bld_w(22, 1), 1'b1, "R5");
        exec(bst_w(5, 4), 1'b1, "R6");
        exec(bld_w(0, 0), 1'b1, "R5");

        // R7: near-miss and foreign words
        exec(flag_w(6, 1'b0), 1'b1, "R2");
        exec(bld_w(12, 4) | 16'h0008, 1'b1, "R7");
        exec(16'h0000, 1'b1, "R7");
        exec(16'h9409, 1'b1, "R7");
        exec(16'hFC00, 1'b1, "R7");
        exec(16'h9508, 1'b1, "R7");
        exec(flag_w(1, 1'b0), 1'b1, "R7");
        check(int'(illegal), 0, "R7");

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        ref_status  = 8'h00;
        ref_illegal = 1'b0;
        for (int i = 0; i < 32; i++) ref_regs[i] = 8'h00;
        compare_all("R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("[TB] FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule